// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address that a synchronous burst memory presents to its array during a four-beat burst. When an address strobe is accepted at a rising clock edge, the whole input address is registered and its two low bits become the starting beat. After that, each clock edge with the advance input held low moves to the next beat. The low two output bits walk through the burst, and the upper bits keep the captured value.

There are two strobes. One belongs to the processor and counts only while the first chip enable is low. The other belongs to the external controller and is not gated. If both count in the same cycle, the processor strobe wins, and only one capture takes place.

A static strap selects the beat order. The linear order adds the beat number to the start modulo four. The interleaved order XORs the beat number into the start. The input is a plain input port, so a floating strap has to be tied high outside the block to get the interleaved default.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, `addr_o` is all zeros.
- R2: An accepted strobe at a rising edge makes `addr_o` equal to the `addr_i` sampled at that edge, starting from the next edge.
- R3: When `proc_strb_ni` and `ctrl_strb_ni` are both low and `ce1_ni` is low, exactly one capture of `addr_i` takes place, and the processor strobe is the one recognised.
- R4: A low `proc_strb_ni` while `ce1_ni` is high, with `ctrl_strb_ni` high and `adv_ni` high, causes no capture, and `addr_o` keeps its previous value.
- R5: A low `ctrl_strb_ni` is accepted whatever the level of `ce1_ni`.
- R6: With no accepted strobe and `adv_ni` high, `addr_o` holds its value.
- R7: With `order_i` = 0 (linear), the k-th advance after a capture gives `addr_o[1:0]` = (start + k) mod 4.
- R8: With `order_i` = 1 (interleaved), the k-th advance after a capture gives `addr_o[1:0]` = start XOR (k mod 4).
- R9: After the fourth advance the low bits return to the start value, and further advances repeat the same sequence.
- R10: An accepted strobe reloads the start address even when `adv_ni` is low in the same cycle.
- R11: Bits above bit 1 of `addr_o` do not change between captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, released synchronously |
| addr_i | input | ADDR_W | Address sampled on an accepted strobe |
| proc_strb_ni | input | 1 | Processor address strobe, active low, gated by `ce1_ni` |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low, lower priority |
| ce1_ni | input | 1 | First chip enable, active low; qualifies the processor strobe |
| adv_ni | input | 1 | Burst advance, active low |
| order_i | input | 1 | Static strap: 0 selects linear order, 1 selects interleaved order |
| addr_o | output | ADDR_W | Registered address with the burst beat in the low bits |

## Verification
The assertions check on every cycle that a capture reproduces the sampled address, that only one strobe is recognised at a time, and that the processor strobe is blocked while the chip enable is high. They also check that the beat count holds or steps by exactly one as `adv_ni` commands, and that the upper address bits stay fixed between captures. The actual linear and interleaved sequences, the return to the start after four beats, and the override of a pending advance by a new strobe depend on the start value and on the history since the last capture. Only the bench's sweep over every start value, strobe kind and order shows these.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } strobe_src_e;

endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
  import burst_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        proc_strb_ni,
  input  logic        ctrl_strb_ni,
  input  logic        ce1_ni,
  output logic        load_o,
  output strobe_src_e src_o
);

  logic proc_take;
  logic ctrl_take;

  always_comb begin
    proc_take = !proc_strb_ni && !ce1_ni;
    ctrl_take = !ctrl_strb_ni && !proc_take;
    if (proc_take)      src_o = SRC_PROC;
    else if (ctrl_take) src_o = SRC_CTRL;
    else                src_o = SRC_NONE;
    load_o = proc_take || ctrl_take;
  end

  // R4: the processor strobe is never taken with the chip enable high
  assert_proc_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce1_ni |-> (src_o != SRC_PROC));

  // R3: only one strobe is recognised, and the processor wins a tie
  assert_single_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strb_ni && !ce1_ni) |-> (src_o == SRC_PROC));

  // R5: the controller strobe is taken whatever the chip enable
  assert_ctrl_accepted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_strb_ni |-> load_o);

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic              adv_ni,
  output logic [BEAT_W-1:0] start_o,
  output logic [BEAT_W-1:0] beat_o
);

  logic [BEAT_W-1:0] start_q, start_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              start_en;
  logic              beat_en;

  always_comb begin
    start_en = load_i;
    start_d  = start_i;
    beat_en  = load_i || !adv_ni;
    beat_d   = load_i ? '0 : beat_q + BEAT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (beat_en)  beat_q  <= beat_d;
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;

  // R6: with no load and advance high the beat count holds
  assert_beat_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> $stable(beat_o));

  // R9: each advance steps the beat count by exactly one, with wrap
  assert_beat_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni) |=> (beat_o == $past(beat_o) + BEAT_W'(1)));

  // R10: a load restarts the burst even with advance low
  assert_load_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (beat_o == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] idx_o
);

  logic [BEAT_W-1:0] lin_idx;
  logic [BEAT_W-1:0] ilv_idx;

  always_comb begin
    lin_idx = start_i + beat_i;
    ilv_idx = start_i ^ beat_i;
    idx_o   = (order_i == ORD_INTERLEAVED) ? ilv_idx : lin_idx;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strb_ni,
  input  logic              ctrl_strb_ni,
  input  logic              ce1_ni,
  input  logic              adv_ni,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  strobe_src_e       src;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] idx;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              hi_en;

  burst_strobe_arb u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .proc_strb_ni (proc_strb_ni),
    .ctrl_strb_ni (ctrl_strb_ni),
    .ce1_ni       (ce1_ni),
    .load_o       (load),
    .src_o        (src)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .start_i (addr_i[BEAT_W-1:0]),
    .adv_ni  (adv_ni),
    .start_o (start_q),
    .beat_o  (beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i (start_q),
    .beat_i  (beat_q),
    .order_i (burst_order_e'(order_i)),
    .idx_o   (idx)
  );

  always_comb begin
    hi_en = load;
    hi_d  = addr_i[ADDR_W-1:BEAT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  assign addr_o = {hi_q, idx};

  // R2: an accepted strobe presents the sampled address on the next cycle
  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src != SRC_NONE) |=> (addr_o == $past(addr_i)));

  // R11: upper bits stay fixed between captures
  assert_upper_fixed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

  localparam int AW = 18;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          proc_n, ctrl_n, ce1_n, adv_n, order;
  logic [AW-1:0] addr_out;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .addr_i       (addr),
    .proc_strb_ni (proc_n),
    .ctrl_strb_ni (ctrl_n),
    .ce1_ni       (ce1_n),
    .adv_ni       (adv_n),
    .order_i      (order),
    .addr_o       (addr_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive after the falling edge, let one rising edge pass, sample 2 ns later
  task automatic cycle();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    proc_n = 1'b1; ctrl_n = 1'b1; ce1_n = 1'b0; adv_n = 1'b1;
  endtask

  function automatic logic [1:0] expect_idx(input logic ord, input logic [1:0] s, input int k);
    logic [1:0] kk;
    kk = 2'(k % 4);
    return ord ? (s ^ kk) : 2'((int'(s) + k) % 4);
  endfunction

  initial begin
    rst_n = 1'b0; addr = '0; proc_n = 1'b1; ctrl_n = 1'b1;
    ce1_n = 1'b1; adv_n = 1'b1; order = 1'b1;
    #1;
    check("R1 during reset", addr_out, '0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cycle();
    check("R1 after release", addr_out, '0);

    // sweep: order x strobe kind x start value, six advances (wrap)
    for (int ord = 0; ord < 2; ord++) begin
      for (int kind = 0; kind < 3; kind++) begin
        for (int s = 0; s < 4; s++) begin
          logic [AW-1:0] cap;
          cap = {16'(16'h1357 + 16'(ord * 97 + kind * 31 + s * 5)), 2'(s)};
          @(negedge clk);
          order = ord[0]; addr = cap; adv_n = 1'b1;
          // kind 0: processor only; 1: controller only, ce1 high; 2: both
          proc_n = (kind == 1); ctrl_n = (kind == 0);
          ce1_n  = (kind == 1);
          cycle();
          check(kind == 0 ? "R2 proc capture" : (kind == 1 ? "R5 ctrl capture ce1 high" : "R3 both strobes"),
                addr_out, cap);
          idle_inputs();
          addr = ~cap;
          cycle();
          check("R6 hold without advance", addr_out, cap);
          for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            adv_n = 1'b0;
            cycle();
            check(ord ? (k > 4 ? "R9 wrap interleaved" : "R8 interleaved step")
                      : (k > 4 ? "R9 wrap linear" : "R7 linear step"),
                  addr_out, {cap[AW-1:2], expect_idx(ord[0], 2'(s), k)});
            check("R11 upper bits fixed", {addr_out[AW-1:2], 2'b00}, {cap[AW-1:2], 2'b00});
          end
          // after four more the start would come back; check k=4 equals start
          @(negedge clk) adv_n = 1'b0;
          cycle();
          @(negedge clk) adv_n = 1'b0;
          cycle();
          check("R9 return to start", addr_out, cap);
          idle_inputs();
        end
      end
    end

    // R4: gated processor strobe does nothing
    @(negedge clk);
    order = 1'b0; addr = 18'h2AAA9; proc_n = 1'b0; ce1_n = 1'b0; adv_n = 1'b1;
    cycle();
    check("R2 setup", addr_out, 18'h2AAA9);
    @(negedge clk);
    addr = 18'h15556; proc_n = 1'b0; ce1_n = 1'b1; ctrl_n = 1'b1;
    cycle();
    check("R4 gated proc strobe ignored", addr_out, 18'h2AAA9);

    // R10: strobe with advance low reloads start
    @(negedge clk);
    ce1_n = 1'b0; adv_n = 1'b0; proc_n = 1'b1; ctrl_n = 1'b1;
    cycle();
    check("R10 pre-advance", addr_out, 18'h2AAAA);
    @(negedge clk);
    addr = 18'h0F0F3; ctrl_n = 1'b0; adv_n = 1'b0;
    cycle();
    check("R10 strobe overrides advance", addr_out, 18'h0F0F3);
    idle_inputs();
    cycle();
    check("R10 hold after reload", addr_out, 18'h0F0F3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule